// File: doc/BRIEF.md
# Reloadable Instruction Store with Core Hold

This block is the instruction memory of a very small processor core, built from plain flip-flops so that it can be rewritten after the chip is made. A synchronous reset fills every word from a boot-image parameter. From then on, a loader can overwrite one word at a time through a write port. The core reads instructions through a fetch port with no clock delay.

The block also generates the reset seen by the core. While the load-select input is high, the core is frozen in reset, so a new program can be written safely. When load-select drops, the core leaves reset on the next clock edge and starts fetching from whatever the store holds. If nothing was loaded, the core runs the boot image exactly as it was reset.

Top module: `imem_reload`

## Requirements
- R1: On every clock edge where `rst` is high, each entry k (0..31) is loaded with the boot-image word. With the default image, that word is 32'hC0DE_0000 + k*32'h0001_0011, modulo 2^32.
- R2: With `rst` low, a clock edge where `wr_en` is high stores `wr_data` into the entry addressed by `wr_addr`. Every other entry keeps its value.
- R3: `fetch_word` returns the entry selected by `fetch_pc[6:2]`, combinationally, in the same cycle. The other bits of `fetch_pc` have no effect on it.
- R4: If a write and a fetch target the same entry in one cycle, `fetch_word` shows the old value in that cycle and the new value after the edge.
- R5: `core_rst` is high in the same cycle, without waiting for a clock edge, whenever `rst` is high or `load_sel` is high.
- R6: After `load_sel` falls (with `rst` low), `core_rst` stays high until the first clock edge that samples `load_sel` low, and goes low after that edge. Leaving `rst` behaves the same way.
- R7: Writes take effect whether `load_sel` is high or low.
- R8: A reset edge overrides a write issued in the same cycle: the addressed entry takes its boot word, not `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads the boot image |
| load_sel | input | 1 | High while a program is being loaded; freezes the core |
| wr_en | input | 1 | Write strobe for one word |
| wr_addr | input | 5 | Word index to write |
| wr_data | input | 32 | Word to write |
| fetch_pc | input | 32 | Core program counter (byte address) |
| fetch_word | output | 32 | Instruction at `fetch_pc[6:2]` |
| core_rst | output | 1 | Active-high reset for the core |

## Verification
Fetch results are due in the same cycle as the address, so the bench sets `fetch_pc` and samples one time unit later, with no clock edge in between. A write lands on the next rising edge, so the bench drives writes at a falling edge and reads back at the following falling edge. For the same-entry case, it also samples before that edge to see the old value. `core_rst` rises in the same cycle as `load_sel` or `rst` and is checked one time unit after the input changes. Its release takes exactly one edge, so the bench checks that it is still high just after the drop and low at the next falling edge.

// File: rtl/imem_pkg.sv
package imem_pkg;

    localparam int IMEM_DEPTH  = 32;
    localparam int IMEM_WIDTH  = 32;
    localparam int PC_WIDTH    = 32;
    localparam int WORD_SHIFT  = 2;

    localparam logic [IMEM_WIDTH-1:0] BOOT_BASE = 32'hC0DE_0000;
    localparam logic [IMEM_WIDTH-1:0] BOOT_STEP = 32'h0001_0011;

    typedef enum logic {
        HOLD_RUN    = 1'b0,
        HOLD_FROZEN = 1'b1
    } hold_e;

    function automatic logic [IMEM_WIDTH-1:0] boot_word(input int idx);
        return BOOT_BASE + IMEM_WIDTH'(idx) * BOOT_STEP;
    endfunction

    function automatic logic [IMEM_DEPTH*IMEM_WIDTH-1:0] default_image();
        logic [IMEM_DEPTH*IMEM_WIDTH-1:0] img;
        img = '0;
        for (int k = 0; k < IMEM_DEPTH; k++) begin
            img[k*IMEM_WIDTH +: IMEM_WIDTH] = boot_word(k);
        end
        return img;
    endfunction

endpackage

// File: rtl/imem_wr_decode.sv
module imem_wr_decode #(
    parameter int DEPTH = imem_pkg::IMEM_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             en,
    input  logic [AW-1:0]    addr,
    output logic [DEPTH-1:0] sel
);
    always_comb begin
        sel = '0;
        for (int k = 0; k < DEPTH; k++) begin
            sel[k] = en && (addr == AW'(k));
        end
    end
endmodule

// File: rtl/imem_store.sv
module imem_store #(
    parameter int DEPTH = imem_pkg::IMEM_DEPTH,
    parameter int WIDTH = imem_pkg::IMEM_WIDTH,
    parameter logic [DEPTH*WIDTH-1:0] BOOT_IMAGE = imem_pkg::default_image()
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DEPTH-1:0]             sel,
    input  logic [WIDTH-1:0]             wr_data,
    output logic [DEPTH-1:0][WIDTH-1:0]  store_q
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                store_q[g] <= BOOT_IMAGE[g*WIDTH +: WIDTH];
            end else if (sel[g]) begin
                store_q[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/imem_fetch_mux.sv
module imem_fetch_mux #(
    parameter int DEPTH = imem_pkg::IMEM_DEPTH,
    parameter int WIDTH = imem_pkg::IMEM_WIDTH,
    parameter int PC_W  = imem_pkg::PC_WIDTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] store_q,
    input  logic [PC_W-1:0]             fetch_pc,
    output logic [WIDTH-1:0]            fetch_word
);
    logic [AW-1:0] word_idx;
    logic          unused_pc_bits;

    assign word_idx       = fetch_pc[imem_pkg::WORD_SHIFT +: AW];
    assign unused_pc_bits = ^fetch_pc;

    always_comb begin
        fetch_word = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (word_idx == AW'(k)) begin
                fetch_word = store_q[k];
            end
        end
    end
endmodule

// File: rtl/core_hold.sv
module core_hold (
    input  logic clk,
    input  logic rst,
    input  logic load_sel,
    output logic core_rst
);
    imem_pkg::hold_e hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= imem_pkg::HOLD_FROZEN;
        end else if (load_sel) begin
            hold_q <= imem_pkg::HOLD_FROZEN;
        end else begin
            hold_q <= imem_pkg::HOLD_RUN;
        end
    end

    assign core_rst = rst || load_sel || (hold_q == imem_pkg::HOLD_FROZEN);
endmodule

// File: rtl/imem_reload.sv
module imem_reload #(
    parameter int DEPTH = imem_pkg::IMEM_DEPTH,
    parameter int WIDTH = imem_pkg::IMEM_WIDTH,
    parameter int PC_W  = imem_pkg::PC_WIDTH,
    parameter logic [DEPTH*WIDTH-1:0] BOOT_IMAGE = imem_pkg::default_image(),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_sel,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic [WIDTH-1:0] fetch_word,
    output logic             core_rst
);
    logic [DEPTH-1:0]            wr_sel;
    logic [DEPTH-1:0][WIDTH-1:0] store_q;

    imem_wr_decode #(.DEPTH(DEPTH)) u_dec (
        .en   (wr_en),
        .addr (wr_addr),
        .sel  (wr_sel)
    );

    imem_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BOOT_IMAGE(BOOT_IMAGE)) u_store (
        .clk     (clk),
        .rst     (rst),
        .sel     (wr_sel),
        .wr_data (wr_data),
        .store_q (store_q)
    );

    imem_fetch_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PC_W(PC_W)) u_fetch (
        .store_q    (store_q),
        .fetch_pc   (fetch_pc),
        .fetch_word (fetch_word)
    );

    core_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .load_sel (load_sel),
        .core_rst (core_rst)
    );
endmodule

// File: rtl/imem_reload_chk.sv
module imem_reload_chk #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    parameter logic [DEPTH*WIDTH-1:0] BOOT_IMAGE = '0,
    localparam int AW = $clog2(DEPTH)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        load_sel,
    input logic                        wr_en,
    input logic [AW-1:0]               wr_addr,
    input logic [WIDTH-1:0]            wr_data,
    input logic [DEPTH-1:0][WIDTH-1:0] store_q,
    input logic                        core_rst
);
    AST_BOOT_IMAGE_LOADED: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (store_q == BOOT_IMAGE)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !$past(rst)) |=> (store_q[$past(wr_addr)] == $past(wr_data))); // R2

    AST_IDLE_STORE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !$past(rst)) |=> $stable(store_q)); // R2

    AST_HELD_DURING_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_sel |-> core_rst); // R5

    AST_RELEASE_WAITS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(load_sel) |-> core_rst); // R6

    AST_RELEASED_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!load_sel && !$past(load_sel) && !$past(rst)) |-> !core_rst); // R6
endmodule

bind imem_reload imem_reload_chk #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .BOOT_IMAGE(BOOT_IMAGE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_sel (load_sel),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .store_q  (store_q),
    .core_rst (core_rst)
);

// File: tb/imem_reload_test.sv
module imem_reload_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic [4:0]  raddr;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{5'd0,  32'h0000_0001, 5'd1},
        '{5'd31, 32'hFFFF_FFFF, 5'd30},
        '{5'd7,  32'hDEAD_BEEF, 5'd8},
        '{5'd16, 32'h1234_5678, 5'd0},
        '{5'd7,  32'h0BAD_F00D, 5'd7},
        '{5'd1,  32'h0000_0000, 5'd31},
        '{5'd20, 32'hA5A5_5A5A, 5'd19},
        '{5'd15, 32'h8000_0000, 5'd16}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        load_sel;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic [31:0] fetch_pc;
    logic [31:0] fetch_word;
    logic        core_rst;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    imem_reload uut (
        .clk(clk), .rst(rst), .load_sel(load_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .fetch_pc(fetch_pc),
        .fetch_word(fetch_word), .core_rst(core_rst)
    );

    function automatic logic [31:0] boot_val(input int k);
        return 32'hC0DE_0000 + 32'(k) * 32'h0001_0011;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic read_word(input string tag, input logic [4:0] idx, input logic [31:0] junk);
        fetch_pc = {junk[31:7], idx, junk[1:0]};
        #1;
        check(tag, fetch_word, model[idx]);
    endtask

    task automatic sweep(input string tag, input logic [31:0] seed);
        for (int k = 0; k < 32; k++) begin
            read_word(tag, 5'(k), seed ^ (32'(k) * 32'h9E37_79B9));
        end
    endtask

    task automatic reset_model();
        for (int k = 0; k < 32; k++) model[k] = boot_val(k);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; load_sel = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; fetch_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5 core_rst during rst", 32'(core_rst), 32'd1);
        rst = 1'b0;
        #1;
        check("R6 core_rst held until edge after rst", 32'(core_rst), 32'd1);
        @(negedge clk);
        check("R6 core_rst released after edge", 32'(core_rst), 32'd0);

        reset_model();
        sweep("R1 boot image / R3 pc bits ignored", 32'hFFFF_FFFF);
        sweep("R3 fetch with other pc bits", 32'h5A5A_0003);

        // pulse load_sel: asserted at once
        @(negedge clk);
        load_sel = 1'b1;
        #1;
        check("R5 core_rst rises with load_sel", 32'(core_rst), 32'd1);

        // vector table
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = VECS[i].waddr; wr_data = VECS[i].wdata;
            @(negedge clk);
            wr_en = 1'b0;
            model[VECS[i].waddr] = VECS[i].wdata;
            read_word("R2 written entry", VECS[i].waddr, 32'(i) * 32'h0101_0101);
            read_word("R2 neighbour entry", VECS[i].raddr, ~(32'(i) * 32'h0303_0303));
        end
        sweep("R2 full store after writes", 32'h1357_9BDF);

        // same-cycle write and fetch
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd12; wr_data = 32'hFEED_FACE;
        read_word("R4 old value in write cycle", 5'd12, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        model[12] = 32'hFEED_FACE;
        read_word("R4 new value after edge", 5'd12, 32'h0);

        // release
        @(negedge clk);
        load_sel = 1'b0;
        #1;
        check("R6 core_rst still high after load_sel falls", 32'(core_rst), 32'd1);
        @(negedge clk);
        check("R6 core_rst low one edge later", 32'(core_rst), 32'd0);
        sweep("R2 contents kept across release", 32'h0F0F_F0F0);

        // write while running
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd3; wr_data = 32'h3333_CAFE;
        @(negedge clk);
        wr_en = 1'b0;
        model[3] = 32'h3333_CAFE;
        read_word("R7 write with load_sel low", 5'd3, 32'hABCD_EF01);
        check("R7 core not held by write", 32'(core_rst), 32'd0);

        // one-cycle load_sel pulse
        @(negedge clk);
        load_sel = 1'b1;
        #1;
        check("R5 pulse asserts core_rst", 32'(core_rst), 32'd1);
        @(negedge clk);
        load_sel = 1'b0;
        #1;
        check("R6 pulse release waits edge", 32'(core_rst), 32'd1);
        @(negedge clk);
        check("R6 pulse released", 32'(core_rst), 32'd0);

        // reset overrides simultaneous write
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h9999_9999;
        #1;
        check("R5 core_rst rises with rst", 32'(core_rst), 32'd1);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        reset_model();
        read_word("R8 reset beats write", 5'd9, 32'h0);
        sweep("R1 image reloaded by reset", 32'h2468_ACE0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule